// File: doc/BRIEF.md
# Pipelined Read Return Tracker

This block sits next to the request sequencer of a graphics bus master that issues pipelined reads. It decodes the 3-bit status code that the bus arbiter presents together with grant. It also tracks outstanding read requests in two priority classes and counts each returned data beat against the oldest request of the class being served. Moving the data, supplying write data and pin timing belong to other blocks.

The sequencer reports each read it enqueues on the bus, giving its priority and its length in 32-bit beats. Each class keeps its own in-order queue, and both queues share one capacity of four requests. A granted status code names the class whose data comes next. That selection stays in force until a later granted code replaces it, and every clock with both ready strobes high is one beat. When the last beat of the oldest request in a class arrives, the block gives a completion pulse for that class. The block throttles low-priority returns with a buffer-full output, which it derives from the free space the return buffer reports. It raises an error pulse on protocol violations.

Top module: `agp_rd_tracker`

## Requirements
- R1: While `gnt_i` is high, `st_dec_o` is one-hot with bit `st_i` set. Codes: 0 low-priority read return, 1 high-priority read return, 2 low-priority write data, 3 high-priority write data, 4 to 6 reserved, 7 start of a bus transaction.
- R2: While `gnt_i` is low, `st_dec_o` is zero and `st_i` has no effect on the selected return class or on `err_o`.
- R3: A granted code 0 selects the low-priority class and a granted code 1 selects the high-priority class. Any other granted code selects no class. The selection holds until the next granted code, and a beat in the same cycle as the code already uses the new selection.
- R4: A beat is a clock with `trdy_i` and `irdy_i` both high. A beat under a selected class decrements the remaining length of that class's oldest request. On the beat that exhausts it, the request retires and `done_lo_o` or `done_hi_o` pulses for one cycle in the cycle after that beat.
- R5: Within a class, requests retire in enqueue order. Beats for one class never change the other class's requests.
- R6: At most 4 requests are outstanding across both classes. An enqueue made while 4 are outstanding (counted before that cycle's retirements) is dropped and pulses `err_o` in the next cycle.
- R7: `rbf_o` is high exactly when `buf_free_i` is less than the largest remaining length among outstanding low-priority requests. Outstanding high-priority requests do not affect it.
- R8: A granted code from 2 to 6 pulses `err_o` in the next cycle.
- R9: A beat under a selected class that has no outstanding request is ignored and pulses `err_o` in the next cycle. Beats while no class is selected are ignored silently.
- R10: An enqueue with a length of zero is dropped and pulses `err_o` in the next cycle.
- R11: After reset, no request is outstanding, no class is selected, and `err_o`, `done_lo_o`, `done_hi_o` and `rbf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Sampled bus grant, high when granted |
| st_i | input | 3 | Status code from the arbiter |
| trdy_i | input | 1 | Target ready, active high |
| irdy_i | input | 1 | Initiator ready, active high |
| enq_valid_i | input | 1 | A read request was enqueued on the bus |
| enq_hi_i | input | 1 | Enqueued request is high priority |
| enq_len_i | input | LEN_W | Request length in 32-bit beats |
| buf_free_i | input | FREE_W | Free entries in the local return buffer |
| st_dec_o | output | 8 | One-hot decoded status |
| rbf_o | output | 1 | Return buffer full, blocks low-priority returns |
| done_lo_o | output | 1 | A low-priority request completed |
| done_hi_o | output | 1 | A high-priority request completed |
| err_o | output | 1 | Protocol error pulse |

## Verification
The hardest state to reach is one where both queues hold requests, one head is partly drained, and an enqueue, a retiring beat and a new granted code all land in the same cycle. In that state capacity is judged on the counts from before the cycle, and the beat must use the code that arrives with it. Random stimulus biases grant toward the two return codes and keeps lengths short, so the queues keep filling and emptying. Directed sequences set up the full queue, a beat with nothing outstanding, and the buffer-full boundary one entry on each side.

// File: rtl/agp_trk_pkg.sv
package agp_trk_pkg;
  localparam logic [2:0] ST_RET_LO = 3'd0;
  localparam logic [2:0] ST_RET_HI = 3'd1;
  localparam logic [2:0] ST_WR_LO  = 3'd2;
  localparam logic [2:0] ST_WR_HI  = 3'd3;
  localparam logic [2:0] ST_START  = 3'd7;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } ret_sel_e;
endpackage

// File: rtl/agp_st_decode.sv
module agp_st_decode
  import agp_trk_pkg::*;
(
  input  logic       gnt_i,
  input  logic [2:0] st_i,
  output logic [7:0] dec_o,
  output logic       ret_lo_o,
  output logic       ret_hi_o,
  output logic       bad_o
);
  always_comb begin
    dec_o = '0;
    if (gnt_i) dec_o[st_i] = 1'b1;
  end

  assign ret_lo_o = dec_o[ST_RET_LO];
  assign ret_hi_o = dec_o[ST_RET_HI];
  // this master issues reads only: write-data codes are violations too
  assign bad_o    = gnt_i & (st_i != ST_RET_LO) & (st_i != ST_RET_HI) & (st_i != ST_START);
endmodule

// File: rtl/agp_rd_fifo.sv
module agp_rd_fifo #(
  parameter int DEPTH = 4,
  parameter int LEN_W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             beat_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [LEN_W-1:0] max_o,
  output logic             last_o
);
  logic [LEN_W-1:0] rem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q, idx;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  assign pop    = beat_i && rem_q[rd_q] == LEN_W'(1);
  assign last_o = pop;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) rem_q[i] <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        rem_q[wr_q] <= len_i;
        wr_q        <= wr_q + PTR_W'(1);
      end
      if (beat_i) begin
        if (pop) rd_q <= rd_q + PTR_W'(1);
        else     rem_q[rd_q] <= rem_q[rd_q] - LEN_W'(1);
      end
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop);
    end
  end

  // largest remaining length among valid entries
  always_comb begin
    max_o = '0;
    idx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = rd_q + PTR_W'(k);
      if (CNT_W'(k) < cnt_q && rem_q[idx] > max_o) max_o = rem_q[idx];
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_beat_nonempty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> cnt_q != '0);
  p_push_room_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q != CNT_W'(DEPTH));
endmodule

// File: rtl/agp_rd_tracker.sv
module agp_rd_tracker
  import agp_trk_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 4,
  parameter int FREE_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_i,
  input  logic [2:0]        st_i,
  input  logic              trdy_i,
  input  logic              irdy_i,
  input  logic              enq_valid_i,
  input  logic              enq_hi_i,
  input  logic [LEN_W-1:0]  enq_len_i,
  input  logic [FREE_W-1:0] buf_free_i,
  output logic [7:0]        st_dec_o,
  output logic              rbf_o,
  output logic              done_lo_o,
  output logic              done_hi_o,
  output logic              err_o
);
  logic ret_lo, ret_hi, bad_code;
  ret_sel_e sel_q, sel_eff;
  logic beat, beat_ok [2], orphan, total_full, push_ok, err_d;
  logic [CNT_W-1:0] cls_cnt [2];
  logic [LEN_W-1:0] cls_max [2];
  logic             cls_last [2];

  agp_st_decode u_dec (
    .gnt_i   (gnt_i),
    .st_i    (st_i),
    .dec_o   (st_dec_o),
    .ret_lo_o(ret_lo),
    .ret_hi_o(ret_hi),
    .bad_o   (bad_code)
  );

  always_comb begin
    if (ret_lo)      sel_eff = SEL_LO;
    else if (ret_hi) sel_eff = SEL_HI;
    else if (gnt_i)  sel_eff = SEL_NONE;
    else             sel_eff = sel_q;
  end

  assign beat       = trdy_i & irdy_i;
  assign beat_ok[0] = beat && sel_eff == SEL_LO && cls_cnt[0] != '0;
  assign beat_ok[1] = beat && sel_eff == SEL_HI && cls_cnt[1] != '0;
  assign orphan     = beat && ((sel_eff == SEL_LO && cls_cnt[0] == '0) ||
                               (sel_eff == SEL_HI && cls_cnt[1] == '0));
  assign total_full = ({1'b0, cls_cnt[0]} + {1'b0, cls_cnt[1]}) == (CNT_W+1)'(DEPTH);
  assign push_ok    = enq_valid_i && enq_len_i != '0 && !total_full;
  assign err_d      = bad_code | orphan | (enq_valid_i & ~push_ok);

  for (genvar c = 0; c < 2; c++) begin : g_cls
    agp_rd_fifo #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_fifo (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .push_i(push_ok && enq_hi_i == c[0]),
      .len_i (enq_len_i),
      .beat_i(beat_ok[c]),
      .cnt_o (cls_cnt[c]),
      .max_o (cls_max[c]),
      .last_o(cls_last[c])
    );
  end

  assign rbf_o = {{(FREE_W > LEN_W ? 0 : LEN_W - FREE_W){1'b0}}, buf_free_i} <
                 {{(LEN_W > FREE_W ? 0 : FREE_W - LEN_W){1'b0}}, cls_max[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= SEL_NONE;
      done_lo_o <= 1'b0;
      done_hi_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      sel_q     <= sel_eff;
      done_lo_o <= cls_last[0];
      done_hi_o <= cls_last[1];
      err_o     <= err_d;
    end
  end

  p_dec_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |-> $onehot(st_dec_o));
  p_gnt_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_i |-> st_dec_o == '0);
  p_done_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_lo_o && done_hi_o));
  p_done_after_beat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_lo_o || done_hi_o) |-> $past(trdy_i && irdy_i));
  p_rbf_needs_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbf_o |-> cls_cnt[0] != '0);
  p_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cls_cnt[0]} + {1'b0, cls_cnt[1]}) <= (CNT_W+1)'(DEPTH));
endmodule

// File: tb/agp_rd_tracker_tb_top.sv
`timescale 1ns/1ps
module agp_rd_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gnt = 1'b0, trdy = 1'b0, irdy = 1'b0, enq_v = 1'b0, enq_h = 1'b0;
  logic [2:0] st = '0;
  logic [3:0] enq_l = '0;
  logic [4:0] bfree = '0;
  logic [7:0] st_dec;
  logic       rbf, dlo, dhi, err;

  int n_chk = 0, n_err = 0;
  int lo_q[4], hi_q[4];
  int lo_n = 0, hi_n = 0, sel = 0;
  logic exp_dlo = 0, exp_dhi = 0, exp_err = 0;

  always #10 clk = ~clk;

  agp_rd_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt), .st_i(st), .trdy_i(trdy), .irdy_i(irdy),
    .enq_valid_i(enq_v), .enq_hi_i(enq_h), .enq_len_i(enq_l), .buf_free_i(bfree),
    .st_dec_o(st_dec), .rbf_o(rbf), .done_lo_o(dlo), .done_hi_o(dhi), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lo_max();
    int m = 0;
    for (int k = 0; k < lo_n; k++) if (lo_q[k] > m) m = lo_q[k];
    return m;
  endfunction

  // one clock: check registered outputs, drive, check combinational, update model
  task automatic step(input logic g, input logic [2:0] s, input logic t, input logic i,
                      input logic e, input logic h, input logic [3:0] l, input logic [4:0] f);
    int eff, full;
    chk(dlo === exp_dlo, "R3 R4 R5 done_lo", dlo, exp_dlo);
    chk(dhi === exp_dhi, "R3 R4 R5 done_hi", dhi, exp_dhi);
    chk(err === exp_err, "R6 R8 R9 R10 err", err, exp_err);
    gnt = g; st = s; trdy = t; irdy = i; enq_v = e; enq_h = h; enq_l = l; bfree = f;
    #1;
    chk(st_dec === (g ? 8'(1) << s : 8'h00), "R1 R2 decode", st_dec, g ? 8'(1) << s : 0);
    chk(rbf === (int'(f) < lo_max()), "R7 rbf", rbf, int'(f) < lo_max());
    exp_dlo = 0; exp_dhi = 0; exp_err = 0;
    full = (lo_n + hi_n == 4);
    eff = (g && s == 0) ? 1 : (g && s == 1) ? 2 : g ? 0 : sel;
    sel = eff;
    if (g && s >= 2 && s <= 6) exp_err = 1;
    if (t && i && eff == 1) begin
      if (lo_n == 0) exp_err = 1;
      else begin
        lo_q[0]--;
        if (lo_q[0] == 0) begin
          for (int k = 0; k < 3; k++) lo_q[k] = lo_q[k+1];
          lo_n--; exp_dlo = 1;
        end
      end
    end
    if (t && i && eff == 2) begin
      if (hi_n == 0) exp_err = 1;
      else begin
        hi_q[0]--;
        if (hi_q[0] == 0) begin
          for (int k = 0; k < 3; k++) hi_q[k] = hi_q[k+1];
          hi_n--; exp_dhi = 1;
        end
      end
    end
    if (e) begin
      if (l == 0 || full) exp_err = 1;
      else if (h) begin hi_q[hi_n] = l; hi_n++; end
      else begin lo_q[lo_n] = l; lo_n++; end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 5'd16);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: quiet after reset
    chk({dlo, dhi, err, rbf} === 4'b0, "R11 reset", {dlo, dhi, err, rbf}, 0);
    // R3 R4 R5: one request per class, each drained
    step(0, 0, 0, 0, 1, 0, 3, 16);
    step(0, 0, 0, 0, 1, 1, 2, 16);
    step(1, 0, 1, 1, 0, 0, 0, 16);
    step(0, 3, 1, 1, 0, 0, 0, 16);   // R2: ungranted code 3 ignored
    step(0, 0, 1, 1, 0, 0, 0, 16);
    step(1, 1, 1, 1, 0, 0, 0, 16);
    step(0, 0, 1, 1, 0, 0, 0, 16);
    idle(2);
    // R8: reserved and write-data codes
    step(1, 5, 0, 0, 0, 0, 0, 16);
    step(1, 2, 0, 0, 0, 0, 0, 16);
    step(1, 7, 1, 1, 0, 0, 0, 16);   // beat with no class: silent
    // R9: beat on empty class
    step(1, 0, 1, 1, 0, 0, 0, 16);
    // R10: zero length
    step(0, 0, 0, 0, 1, 0, 0, 16);
    // R6: fill four, fifth dropped
    step(0, 0, 0, 0, 1, 0, 4, 16);
    step(0, 0, 0, 0, 1, 1, 1, 16);
    step(0, 0, 0, 0, 1, 0, 2, 16);
    step(0, 0, 0, 0, 1, 1, 1, 16);
    step(0, 0, 0, 0, 1, 0, 1, 16);
    // R7: boundary on largest low length (4)
    step(0, 0, 0, 0, 0, 0, 0, 3);
    step(0, 0, 0, 0, 0, 0, 0, 4);
    idle(1);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic g, t, i, e, h; logic [2:0] s; logic [3:0] l;
      g = ($urandom % 2) == 0;
      r = $urandom % 20;
      s = (r < 8) ? 3'd0 : (r < 16) ? 3'd1 : (r < 18) ? 3'd7 : 3'($urandom % 8);
      t = ($urandom % 3) != 0;
      i = ($urandom % 3) != 0;
      e = ($urandom % 4) == 0;
      h = ($urandom % 2) == 0;
      l = (($urandom % 16) == 0) ? 4'd0 : 4'(1 + $urandom % 4);
      step(g, s, t, i, e, h, l, 5'($urandom % 8));
    end
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule